// File: doc/BRIEF.md
# IO Virtual Address Translator

This block turns a device's 32-bit DMA virtual address into a physical address by looking it up in a single-level page table in system memory. A programmable window, chosen by a 3-bit code in the control register, sets which upper address bits are removed before indexing. Each 4 KB page has one 32-bit entry. The entry address is the table base register shifted left by four, plus a word-aligned index formed from the masked virtual address. The entry stores physical address bits 30:12 in bits 26:8, so the fetched field is shifted left by four and the 12-bit page offset is added. Memory holds the entries big-endian; when the read port delivers little-endian words, the block swaps the bytes first.

Software writes a table base and a control word through a word-addressed register port. Register reads are combinational. A device then presents one virtual address at a time on a request/ready handshake. The block issues a single read on its memory master port and returns the physical address, together with a fault flag that is set when the entry's valid bit is clear.

The controller is a four-state machine:
- `ST_IDLE`: accepts a request and latches the masked address and the entry address, then goes to `ST_FETCH`.
- `ST_FETCH`: holds the memory read until it is accepted, then goes to `ST_WAIT`.
- `ST_WAIT`: latches the returned word, then goes to `ST_RESP`.
- `ST_RESP`: holds the response until the device takes it, then returns to `ST_IDLE`.

Top module: `iova_xlate`

## Requirements
- R1: The register index is the byte offset on `cfg_addr` shifted right by two. Index 0 is control and index 1 is the table base. A write to any index stores the full 32-bit word. `cfg_rdata` returns the stored word in the same cycle as `cfg_addr`.
- R2: After reset all registers read zero and the window start is zero. `xl_req_ready` is 1, and `mem_req_valid`, `xl_rsp_valid` and `xl_rsp_fault` are 0.
- R3: A write to index 0 sets the window start from control bits [4:2]. Code k gives `32'hFFFF_FFFF << (24+k)`, which runs from 0xFF000000 for code 0 to 0x80000000 for code 7. The masked address is the virtual address AND NOT the window start.
- R4: `mem_req_addr` = (base << 4) + ((masked >> 10) with bits [1:0] cleared), computed modulo 2^32.
- R5: `xl_rsp_pa` = ((entry AND 0x07FFFF00) << 4) + masked[11:0].
- R6: With `SWAP_BYTES`=1, the entry is `mem_rsp_data` with its four bytes reversed (byte 0 becomes byte 3).
- R7: `xl_rsp_fault` is 1 during the response if entry bit 1 (valid) is 0, and is 0 otherwise and outside a response. The address is returned either way.
- R8: Only one translation is outstanding at a time. `xl_req_ready` is 0 from acceptance until the response handshake completes.
- R9: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` accepts the read.
- R10: `xl_rsp_valid`, `xl_rsp_pa` and `xl_rsp_fault` hold steady until `xl_rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| xl_req_valid | input | 1 | Translation request valid |
| xl_req_ready | output | 1 | Block can accept a request |
| xl_req_va | input | 32 | Virtual address |
| xl_rsp_valid | output | 1 | Response valid |
| xl_rsp_ready | input | 1 | Device takes the response |
| xl_rsp_pa | output | 32 | Physical address |
| xl_rsp_fault | output | 1 | Entry was not valid |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |

## Verification
Assertions check every cycle that:
- a request is never accepted while a fetch or response is pending;
- pending memory reads and responses stay stable;
- the fault flag never appears without a response;
- the window start always has one of its legal contiguous shapes;
- the response carries the page offset and leaves bit 31 clear.

The exact window-to-mask mapping, the entry address and physical address arithmetic, and the byte order of the entry can only be shown by the bench. It sweeps all eight window codes with varied addresses and handshake delays, and compares against values computed from the formulas.

// File: rtl/iova_pkg.sv
package iova_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } xl_state_e;

    localparam int unsigned PAGE_BITS   = 12;
    localparam int unsigned IDX_SHIFT   = PAGE_BITS - 2;
    localparam int unsigned BASE_SHIFT  = 4;
    localparam int unsigned MIN_WIN_LOG = 24;
    localparam logic [31:0] PPN_FIELD   = 32'h07FF_FF00;
    localparam int unsigned VALID_BIT   = 1;

    function automatic logic [31:0] window_start(input logic [2:0] code);
        return 32'hFFFF_FFFF << (MIN_WIN_LOG + int'(code));
    endfunction
endpackage

// File: rtl/iova_regs.sv
module iova_regs #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [31:0]       base,
    output logic [31:0]       win_start
);
    import iova_pkg::*;

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [31:0] regs_q [NUM_REGS];
    logic [31:0] ws_q;
    logic [IDX_W-1:0] idx;

    assign idx = addr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
            ws_q <= '0;
        end else if (we) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (int'(idx) == i) regs_q[i] <= wdata;
            if (idx == '0) ws_q <= window_start(wdata[4:2]);
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (int'(idx) == i) rdata = regs_q[i];
    end

    assign base      = regs_q[1];
    assign win_start = ws_q;

    // R3: window start is zero or a contiguous run of ones from bit 31
    a_r3_win_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ((((~ws_q) & ((~ws_q) + 32'd1)) == 32'd0) && (ws_q == 32'd0 || ws_q[31])));
endmodule

// File: rtl/iova_calc.sv
module iova_calc #(
    parameter bit SWAP_BYTES = 1'b1
) (
    input  logic [31:0] va,
    input  logic [31:0] win_start,
    input  logic [31:0] base,
    output logic [31:0] masked,
    output logic [31:0] ent_addr,
    input  logic [31:0] raw_word,
    output logic [31:0] entry,
    input  logic [31:0] ent_q,
    input  logic [11:0] offset_q,
    output logic [31:0] pa,
    output logic        fault
);
    import iova_pkg::*;

    assign masked   = va & ~win_start;
    assign ent_addr = (base << BASE_SHIFT) + ((masked >> IDX_SHIFT) & ~32'd3);

    generate
        if (SWAP_BYTES) begin : g_swap
            assign entry = {raw_word[7:0], raw_word[15:8], raw_word[23:16], raw_word[31:24]};
        end else begin : g_noswap
            assign entry = raw_word;
        end
    endgenerate

    assign pa    = ((ent_q & PPN_FIELD) << 4) + {20'd0, offset_q};
    assign fault = ~ent_q[VALID_BIT];
endmodule

// File: rtl/iova_ctrl.sv
module iova_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic mem_valid,
    input  logic mem_ready,
    input  logic mem_rsp_valid,
    output logic rsp_valid,
    input  logic rsp_ready,
    output logic load_req,
    output logic load_entry
);
    import iova_pkg::*;

    xl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_FETCH;
            ST_FETCH: if (mem_ready)     state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_RESP;
            ST_RESP:  if (rsp_ready)     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_valid  = (state_q == ST_FETCH);
        rsp_valid  = (state_q == ST_RESP);
        load_req   = (state_q == ST_IDLE) && req_valid;
        load_entry = (state_q == ST_WAIT) && mem_rsp_valid;
    end

    // R8: no acceptance while a fetch or response is pending
    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !rsp_valid));
    // R8: after acceptance the block stops accepting
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate #(
    parameter int unsigned NUM_REGS   = 4,
    parameter int unsigned ADDR_W     = $clog2(NUM_REGS) + 2,
    parameter bit          SWAP_BYTES = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              xl_req_valid,
    output logic              xl_req_ready,
    input  logic [31:0]       xl_req_va,
    output logic              xl_rsp_valid,
    input  logic              xl_rsp_ready,
    output logic [31:0]       xl_rsp_pa,
    output logic              xl_rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    logic [31:0] base, win_start, masked, ent_addr, entry, pa_c;
    logic        fault_c, load_req, load_entry, rsp_v;
    logic [31:0] ent_addr_q, ent_q;
    logic [11:0] offset_q;

    iova_regs #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .base(base), .win_start(win_start)
    );

    iova_calc #(.SWAP_BYTES(SWAP_BYTES)) u_calc (
        .va(xl_req_va), .win_start(win_start), .base(base),
        .masked(masked), .ent_addr(ent_addr),
        .raw_word(mem_rsp_data), .entry(entry),
        .ent_q(ent_q), .offset_q(offset_q), .pa(pa_c), .fault(fault_c)
    );

    iova_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(xl_req_valid), .req_ready(xl_req_ready),
        .mem_valid(mem_req_valid), .mem_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .rsp_valid(rsp_v), .rsp_ready(xl_rsp_ready),
        .load_req(load_req), .load_entry(load_entry)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr_q <= '0;
            offset_q   <= '0;
            ent_q      <= '0;
        end else begin
            if (load_req) begin
                ent_addr_q <= ent_addr;
                offset_q   <= masked[11:0];
            end
            if (load_entry) ent_q <= entry;
        end
    end

    assign mem_req_addr = ent_addr_q;
    assign xl_rsp_valid = rsp_v;
    assign xl_rsp_pa    = pa_c;
    assign xl_rsp_fault = rsp_v & fault_c;

    // R7: fault only qualifies a response
    a_r7_fault_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        xl_rsp_fault |-> xl_rsp_valid);
    // R9: pending entry read holds
    a_r9_memreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R10: pending response holds
    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_rsp_valid && !xl_rsp_ready) |=>
        (xl_rsp_valid && $stable(xl_rsp_pa) && $stable(xl_rsp_fault)));
    // R5: response keeps the page offset and bit 31 clear
    a_r5_pa_shape: assert property (@(posedge clk) disable iff (!rst_n)
        xl_rsp_valid |-> (xl_rsp_pa[11:0] == offset_q && !xl_rsp_pa[31]));
endmodule

// File: tb/iova_xlate_bench.sv
module iova_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        xl_req_valid = 1'b0;
    logic        xl_req_ready;
    logic [31:0] xl_req_va = '0;
    logic        xl_rsp_valid;
    logic        xl_rsp_ready = 1'b0;
    logic [31:0] xl_rsp_pa;
    logic        xl_rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] cur_ws = '0;
    logic [31:0] cur_base = '0;

    always #4 clk = ~clk;

    iova_xlate u_iova_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready), .xl_req_va(xl_req_va),
        .xl_rsp_valid(xl_rsp_valid), .xl_rsp_ready(xl_rsp_ready),
        .xl_rsp_pa(xl_rsp_pa), .xl_rsp_fault(xl_rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] logical_entry(input logic [31:0] a);
        logic [31:0] e;
        e = (a * 32'h9E37_79B1) ^ 32'h1234_5678;
        e[1] = ~a[4];
        return e;
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic reg_write(input int idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(idx << 2); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_check(input int idx, input logic [31:0] exp);
        cfg_addr = 4'(idx << 2);
        #1;
        chk(cfg_rdata == exp, "R1 register readback", cfg_rdata, exp);
    endtask

    task automatic translate(input logic [31:0] va, input int mdly, input int rdly);
        logic [31:0] masked, ea, e, pa, a0, p0;
        masked = va & ~cur_ws;
        ea = (cur_base << 4) + ((masked >> 10) & ~32'd3);
        e  = logical_entry(ea);
        pa = ((e & 32'h07FF_FF00) << 4) + {20'd0, masked[11:0]};
        @(negedge clk);
        xl_req_valid = 1'b1; xl_req_va = va;
        chk(xl_req_ready, "R8 idle ready", 32'(xl_req_ready), 1);
        @(negedge clk);
        xl_req_valid = 1'b0;
        chk(!xl_req_ready, "R8 busy after accept", 32'(xl_req_ready), 0);
        chk(mem_req_valid, "R9 fetch issued", 32'(mem_req_valid), 1);
        chk(mem_req_addr == ea, "R4 entry address", mem_req_addr, ea);
        a0 = mem_req_addr;
        for (int i = 0; i < mdly; i++) begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == a0, "R9 fetch hold", mem_req_addr, a0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid, "R9 fetch retired", 32'(mem_req_valid), 0);
        mem_rsp_valid = 1'b1; mem_rsp_data = bswap(e);
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
        chk(xl_rsp_valid, "R10 response valid", 32'(xl_rsp_valid), 1);
        chk(xl_rsp_pa == pa, "R5 R6 R3 physical address", xl_rsp_pa, pa);
        chk(xl_rsp_fault == ~e[1], "R7 fault flag", 32'(xl_rsp_fault), 32'(~e[1]));
        p0 = xl_rsp_pa;
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            chk(xl_rsp_valid && xl_rsp_pa == p0 && !xl_req_ready, "R10 response hold", xl_rsp_pa, p0);
        end
        xl_rsp_ready = 1'b1;
        @(negedge clk);
        xl_rsp_ready = 1'b0;
        chk(!xl_rsp_valid && xl_req_ready && !xl_rsp_fault, "R8 R7 back to idle",
            {30'd0, xl_rsp_valid, xl_rsp_fault}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] vas [5];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        chk(xl_req_ready, "R2 ready after reset", 32'(xl_req_ready), 1);
        chk(!mem_req_valid && !xl_rsp_valid && !xl_rsp_fault, "R2 idle outputs",
            {29'd0, mem_req_valid, xl_rsp_valid, xl_rsp_fault}, 0);
        for (int i = 0; i < 4; i++) reg_check(i, 32'd0);
        // R2 window start zero: full address used for indexing
        translate(32'h0000_3ABC, 0, 0);
        translate(32'h0001_2FF0, 1, 1);
        // R1 stores at all indices
        reg_write(1, 32'h0010_0000); cur_base = 32'h0010_0000;
        reg_write(2, 32'hCAFE_F00D);
        reg_write(3, 32'h0BAD_1DEA);
        reg_check(1, 32'h0010_0000);
        reg_check(2, 32'hCAFE_F00D);
        reg_check(3, 32'h0BAD_1DEA);
        // R3 sweep of every window code
        for (int k = 0; k < 8; k++) begin
            logic [31:0] ctl;
            ctl = 32'hA500_0001 | (32'(k) << 2) | 32'h0000_FF00;
            reg_write(0, ctl);
            cur_ws = 32'hFFFF_FFFF << (24 + k);
            reg_check(0, ctl);
            vas[0] = cur_ws | 32'h0000_0ABC;
            vas[1] = cur_ws | (32'h0056_7123 + 32'(k) * 32'h0001_1000);
            vas[2] = 32'hFFFF_FFFF;
            vas[3] = 32'h0123_4567;
            vas[4] = 32'h8000_1FFC ^ (32'(k) << 20);
            for (int j = 0; j < 5; j++) translate(vas[j], (j + k) % 3, (j * k) % 3);
        end
        // R1 base change takes effect on next translation
        reg_write(1, 32'hFFF0_0123); cur_base = 32'hFFF0_0123;
        reg_check(1, 32'hFFF0_0123);
        translate(32'hFFFF_F004, 2, 2);
        translate(32'h7FFF_FFFF, 0, 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule